// File: doc/BRIEF.md
# Masked GPIO Port Bank

This block is a general-purpose I/O bank with one narrow port (8 pins) and four wide ports (18 pins each). Every port keeps an output value register and a direction register, and sees its input pins through a two-stage synchroniser. Its outputs drive the pad value and pad output-enable of every pin directly; a direction bit of 1 makes the pin an output and 0 makes it an input.

A simple one-cycle request interface carries eight operations: write, bit-set and bit-clear of the output value, make-input and make-output on the direction register, and three reads (synchronised pins, output value, direction). Every change is filtered through two fixed per-port permission masks chosen by parameters: one for the output value and one for the direction. A bit outside the mask can never change and stays 0 from reset. Each accepted request produces a one-cycle response on the next cycle.

The response path is a two-state machine. In `RSP_IDLE` the response is invalid; in `RSP_SHOW` it is valid. The transition `IDLE->SHOW` and `SHOW->SHOW` happen on any clock edge with a request. The transitions `SHOW->IDLE` and `IDLE->IDLE` happen on any edge without a request. Requests are accepted in both states.

Top module: `mgpio_bank`

## Requirements
- R1: While reset is asserted, all output value bits and all direction bits are 0 (every pin is an input), and the response is invalid.
- R2: A write (op code 0) replaces the output value bits of the addressed port that the port's value permission mask allows, and keeps all other bits unchanged. The response returns the updated output value.
- R3: A bit-set (op code 1) ORs the request data, filtered by the value permission mask, into the output value. The response returns the updated output value. Value bits that the mask forbids always read 0.
- R4: A bit-clear (op code 2) clears the output value bits that are 1 in the request data and allowed by the value permission mask. The response returns the updated output value.
- R5: Make-input (op code 3) clears the direction bits that are selected by the data and allowed by the direction permission mask. The response returns the updated direction register inverted and limited to the port width (1 = input). Direction bits that the mask forbids always read 0.
- R6: Make-output (op code 4) ORs the data, filtered by the direction permission mask, into the direction register. The response returns the updated direction register. It never clears a direction bit.
- R7: A pin read (op code 5) returns the value that the port's input pins had at the clock edge two edges before the one that accepts the read. This comes from the two-stage synchroniser.
- R8: An output read (op code 6) returns the output value and a direction read (op code 7) returns the direction register. Reads change no state. Response bits above the port width are 0. A request to a port index of 5 or higher changes nothing and returns 0.
- R9: The response is valid in exactly the cycle after each clock edge that accepts a request, and invalid otherwise.
- R10: The pad value and pad enable outputs always equal the output value and direction registers. The narrow port sits at pad bits 7:0 and wide port k (k = 0..3, port index k+1) at pad bits 8+18k upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 write, 1 set, 2 clear, 3 make-input, 4 make-output, 5 read pins, 6 read value, 7 read direction) |
| req_port | input | 3 | Port index, 0 narrow, 1 to 4 wide |
| req_data | input | 18 | Mask or value, low bits used for the narrow port |
| rsp_valid | output | 1 | Response valid |
| rsp_data | output | 18 | Response value, zero above the port width |
| pad_i | input | 80 | Input pin levels of all ports |
| pad_o | output | 80 | Pad output values of all ports |
| pad_oe | output | 80 | Pad output enables of all ports, 1 = drive |

## Verification
The bench builds the bank with a narrow-port value mask of 0xF7 and a direction mask of 0x7F, and with different partial masks on each wide port (alternating bits, grouped bits, one fully open port, one port with its top direction bit locked). With these masks, the filtering of writes, sets, clears and direction changes by locked bits can be observed on every port. They also expose any mixing up of the value and direction masks, or of one port's mask with another's. Random requests, which include the unused port indices 5 to 7, are driven together with random pin levels. These expose the two-edge latency of the synchroniser and the zeroing of the bits above the narrow width.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

    typedef enum logic [2:0] {
        OP_WRITE    = 3'd0,
        OP_SET      = 3'd1,
        OP_CLEAR    = 3'd2,
        OP_MAKE_IN  = 3'd3,
        OP_MAKE_OUT = 3'd4,
        OP_RD_PINS  = 3'd5,
        OP_RD_OUT   = 3'd6,
        OP_RD_DIR   = 3'd7
    } bus_op_e;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_SHOW = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/mgpio_sync2.sv
module mgpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
    import mgpio_pkg::*;
#(
    parameter int           W        = 8,
    parameter logic [W-1:0] CHG_BITS = '1,
    parameter logic [W-1:0] CHG_DIR  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  bus_op_e      op,
    input  logic [W-1:0] data,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] dout_o,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] dout_nx,
    output logic [W-1:0] oe_nx,
    output logic [W-1:0] in_view,
    output logic [W-1:0] pins_o
);
    logic [W-1:0] dout_q, oe_q;
    logic [W-1:0] dout_d, oe_d;
    logic [W-1:0] val_sel, dir_sel;

    assign val_sel = data & CHG_BITS;
    assign dir_sel = data & CHG_DIR;

    always_comb begin
        dout_d = dout_q;
        oe_d   = oe_q;
        if (hit) begin
            unique case (op)
                OP_WRITE:    dout_d = (dout_q & ~CHG_BITS) | val_sel;
                OP_SET:      dout_d = dout_q | val_sel;
                OP_CLEAR:    dout_d = dout_q & ~val_sel;
                OP_MAKE_IN:  oe_d   = oe_q & ~dir_sel;
                OP_MAKE_OUT: oe_d   = oe_q | dir_sel;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            oe_q   <= '0;
        end else begin
            dout_q <= dout_d;
            oe_q   <= oe_d;
        end
    end

    mgpio_sync2 #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pins_o)
    );

    assign dout_o  = dout_q;
    assign oe_o    = oe_q;
    assign dout_nx = dout_d;
    assign oe_nx   = oe_d;
    assign in_view = ~oe_d;
endmodule

// File: rtl/mgpio_bank.sv
module mgpio_bank
    import mgpio_pkg::*;
#(
    parameter int                        NARROW_W   = 8,
    parameter int                        WIDE_W     = 18,
    parameter int                        NUM_WIDE   = 4,
    parameter logic [NARROW_W-1:0]       CHG_BITS_N = '1,
    parameter logic [NARROW_W-1:0]       CHG_DIR_N  = '1,
    parameter logic [NUM_WIDE*WIDE_W-1:0] CHG_BITS_W = '1,
    parameter logic [NUM_WIDE*WIDE_W-1:0] CHG_DIR_W  = '1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic [2:0]                          req_op,
    input  logic [$clog2(NUM_WIDE+1)-1:0]       req_port,
    input  logic [WIDE_W-1:0]                   req_data,
    output logic                                rsp_valid,
    output logic [WIDE_W-1:0]                   rsp_data,
    input  logic [NARROW_W+NUM_WIDE*WIDE_W-1:0] pad_i,
    output logic [NARROW_W+NUM_WIDE*WIDE_W-1:0] pad_o,
    output logic [NARROW_W+NUM_WIDE*WIDE_W-1:0] pad_oe
);
    localparam int NUM_PORTS = NUM_WIDE + 1;
    localparam int IDX_W     = $clog2(NUM_PORTS);
    localparam int DATA_W    = WIDE_W;
    localparam int PAD_W     = NARROW_W + NUM_WIDE * WIDE_W;
    localparam logic [PAD_W-1:0] CHG_BITS_ALL = {CHG_BITS_W, CHG_BITS_N};
    localparam logic [PAD_W-1:0] CHG_DIR_ALL  = {CHG_DIR_W, CHG_DIR_N};

    bus_op_e     op;
    logic        port_ok;
    logic [DATA_W-1:0] v_dout [NUM_PORTS];
    logic [DATA_W-1:0] v_oe   [NUM_PORTS];
    logic [DATA_W-1:0] v_dnx  [NUM_PORTS];
    logic [DATA_W-1:0] v_onx  [NUM_PORTS];
    logic [DATA_W-1:0] v_inv  [NUM_PORTS];
    logic [DATA_W-1:0] v_pins [NUM_PORTS];

    assign op      = bus_op_e'(req_op);
    assign port_ok = {1'b0, req_port} < (IDX_W+1)'(NUM_PORTS);

    // Narrow port, index 0
    logic [NARROW_W-1:0] n_dout, n_oe, n_dnx, n_onx, n_inv, n_pins;
    mgpio_port #(
        .W        (NARROW_W),
        .CHG_BITS (CHG_BITS_N),
        .CHG_DIR  (CHG_DIR_N)
    ) u_port_n (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (req_valid && req_port == '0),
        .op      (op),
        .data    (req_data[NARROW_W-1:0]),
        .pin_i   (pad_i[NARROW_W-1:0]),
        .dout_o  (n_dout),
        .oe_o    (n_oe),
        .dout_nx (n_dnx),
        .oe_nx   (n_onx),
        .in_view (n_inv),
        .pins_o  (n_pins)
    );
    assign v_dout[0] = DATA_W'(n_dout);
    assign v_oe[0]   = DATA_W'(n_oe);
    assign v_dnx[0]  = DATA_W'(n_dnx);
    assign v_onx[0]  = DATA_W'(n_onx);
    assign v_inv[0]  = DATA_W'(n_inv);
    assign v_pins[0] = DATA_W'(n_pins);
    assign pad_o[NARROW_W-1:0]  = n_dout;
    assign pad_oe[NARROW_W-1:0] = n_oe;

    // Wide ports, index 1..NUM_WIDE
    for (genvar k = 0; k < NUM_WIDE; k++) begin : g_wide
        localparam int BASE = NARROW_W + k * WIDE_W;
        logic [WIDE_W-1:0] w_dout, w_oe, w_dnx, w_onx, w_inv, w_pins;
        mgpio_port #(
            .W        (WIDE_W),
            .CHG_BITS (CHG_BITS_W[k*WIDE_W +: WIDE_W]),
            .CHG_DIR  (CHG_DIR_W[k*WIDE_W +: WIDE_W])
        ) u_port_w (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (req_valid && req_port == IDX_W'(k + 1)),
            .op      (op),
            .data    (req_data),
            .pin_i   (pad_i[BASE +: WIDE_W]),
            .dout_o  (w_dout),
            .oe_o    (w_oe),
            .dout_nx (w_dnx),
            .oe_nx   (w_onx),
            .in_view (w_inv),
            .pins_o  (w_pins)
        );
        assign v_dout[k+1] = w_dout;
        assign v_oe[k+1]   = w_oe;
        assign v_dnx[k+1]  = w_dnx;
        assign v_onx[k+1]  = w_onx;
        assign v_inv[k+1]  = w_inv;
        assign v_pins[k+1] = w_pins;
        assign pad_o[BASE +: WIDE_W]  = w_dout;
        assign pad_oe[BASE +: WIDE_W] = w_oe;
    end

    // Response value selection
    logic [DATA_W-1:0] rsp_nx;
    always_comb begin
        rsp_nx = '0;
        if (port_ok) begin
            unique case (op)
                OP_WRITE, OP_SET, OP_CLEAR: rsp_nx = v_dnx[req_port];
                OP_MAKE_IN:                 rsp_nx = v_inv[req_port];
                OP_MAKE_OUT:                rsp_nx = v_onx[req_port];
                OP_RD_PINS:                 rsp_nx = v_pins[req_port];
                OP_RD_OUT:                  rsp_nx = v_dout[req_port];
                OP_RD_DIR:                  rsp_nx = v_oe[req_port];
                default:                    rsp_nx = '0;
            endcase
        end
    end

    // Response state machine
    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = req_valid ? RSP_SHOW : RSP_IDLE;
            RSP_SHOW: state_d = req_valid ? RSP_SHOW : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rsp_data <= '0;
        else if (req_valid) rsp_data <= rsp_nx;
    end

    always_comb begin
        rsp_valid = (state_q == RSP_SHOW);
    end
endmodule

// File: rtl/mgpio_bank_chk.sv
module mgpio_bank_chk
    import mgpio_pkg::*;
#(
    parameter int               PAD_W     = 80,
    parameter int               IDX_W     = 3,
    parameter int               NUM_PORTS = 5,
    parameter logic [PAD_W-1:0] LOCK_DOUT = '0,
    parameter logic [PAD_W-1:0] LOCK_OE   = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic [IDX_W-1:0] req_port,
    input logic             rsp_valid,
    input logic [PAD_W-1:0] pad_o,
    input logic [PAD_W-1:0] pad_oe
);
    logic bad_port;
    assign bad_port = {1'b0, req_port} >= (IDX_W+1)'(NUM_PORTS);

    // R9: a response follows every accepted request
    a_r9_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9: no response without a request
    a_r9_quiet_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: forbidden output value bits stay 0
    a_r3_locked_dout_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_o & LOCK_DOUT) == '0);

    // R5: forbidden direction bits stay 0
    a_r5_locked_oe_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & LOCK_OE) == '0);

    // R5: make-input never turns a pin into an output
    a_r5_make_in_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_MAKE_IN) |=> ((pad_oe & ~$past(pad_oe)) == '0));

    // R6: make-output never turns a pin into an input
    a_r6_make_out_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_MAKE_OUT) |=> ((pad_oe & $past(pad_oe)) == $past(pad_oe)));

    // R8: reads and unused port indices leave the pads unchanged
    a_r8_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (bad_port || req_op >= OP_RD_PINS)) |=> ($stable(pad_o) && $stable(pad_oe)));
endmodule

bind mgpio_bank mgpio_bank_chk #(
    .PAD_W     (PAD_W),
    .IDX_W     (IDX_W),
    .NUM_PORTS (NUM_PORTS),
    .LOCK_DOUT (~CHG_BITS_ALL),
    .LOCK_OE   (~CHG_DIR_ALL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_port  (req_port),
    .rsp_valid (rsp_valid),
    .pad_o     (pad_o),
    .pad_oe    (pad_oe)
);

// File: tb/tb_mgpio_bank.sv
`timescale 1ns/1ps
module tb_mgpio_bank;
    localparam logic [7:0]  CB_N = 8'hF7;
    localparam logic [7:0]  CD_N = 8'h7F;
    localparam logic [71:0] CB_W = {18'h3FFFF, 18'h0FF0F, 18'h3C3C3, 18'h2AAAA};
    localparam logic [71:0] CD_W = {18'h1FFFF, 18'h3FFFF, 18'h00FFF, 18'h35555};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [2:0]  req_port = '0;
    logic [17:0] req_data = '0;
    logic        rsp_valid;
    logic [17:0] rsp_data;
    logic [79:0] pad_i = '0;
    logic [79:0] pad_o, pad_oe;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mgpio_bank #(
        .CHG_BITS_N (CB_N), .CHG_DIR_N (CD_N),
        .CHG_BITS_W (CB_W), .CHG_DIR_W (CD_W)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_op (req_op), .req_port (req_port),
        .req_data (req_data), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .pad_i (pad_i), .pad_o (pad_o), .pad_oe (pad_oe)
    );

    function automatic logic [17:0] wmask(int p);
        return (p == 0) ? 18'h000FF : 18'h3FFFF;
    endfunction
    function automatic logic [17:0] cbits(int p);
        return (p == 0) ? {10'd0, CB_N} : CB_W[(p-1)*18 +: 18];
    endfunction
    function automatic logic [17:0] cdir(int p);
        return (p == 0) ? {10'd0, CD_N} : CD_W[(p-1)*18 +: 18];
    endfunction
    function automatic logic [17:0] slice(logic [79:0] v, int p);
        return (p == 0) ? {10'd0, v[7:0]} : v[8 + (p-1)*18 +: 18];
    endfunction

    // Behavioural reference
    logic [17:0] m_dout [5];
    logic [17:0] m_oe   [5];
    logic [79:0] m_pin_q [$];
    logic        e_valid;
    logic [17:0] e_data;
    string       e_tag;
    int          p;
    logic [17:0] d, nd, no, r;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin m_dout[i] = '0; m_oe[i] = '0; end
            m_pin_q = {80'd0, 80'd0};
            e_valid = 1'b0;
            e_data  = '0;
        end else begin
            e_valid = req_valid;
            if (req_valid) begin
                r = '0;
                e_tag = "R8";
                if (req_port < 5) begin
                    p  = int'(req_port);
                    d  = req_data & wmask(p);
                    nd = m_dout[p];
                    no = m_oe[p];
                    case (req_op)
                        3'd0: begin nd = (nd & ~cbits(p)) | (d & cbits(p)); r = nd; e_tag = "R2"; end
                        3'd1: begin nd = nd | (d & cbits(p)); r = nd; e_tag = "R3"; end
                        3'd2: begin nd = nd & ~(d & cbits(p)); r = nd; e_tag = "R4"; end
                        3'd3: begin no = no & ~(d & cdir(p)); r = ~no & wmask(p); e_tag = "R5"; end
                        3'd4: begin no = no | (d & cdir(p)); r = no; e_tag = "R6"; end
                        3'd5: begin r = slice(m_pin_q[0], p); e_tag = "R7"; end
                        3'd6: r = m_dout[p];
                        default: r = m_oe[p];
                    endcase
                    m_dout[p] = nd;
                    m_oe[p]   = no;
                end
                e_data = r;
            end
            void'(m_pin_q.pop_front());
            m_pin_q.push_back(pad_i);
        end
        started = 1;
    end

    task automatic chk(string tag, string what, logic [79:0] act, logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the edge
    always @(negedge clk) begin
        if (started && !done) begin
            if (!rst_n) begin
                chk("R1", "pad_o", pad_o, '0);
                chk("R1", "pad_oe", pad_oe, '0);
                chk("R1", "rsp_valid", {79'd0, rsp_valid}, 80'd0);
            end else begin
                for (int q = 0; q < 5; q++) begin
                    chk("R10", "pad_o", {62'd0, slice(pad_o, q)}, {62'd0, m_dout[q]});
                    chk("R10", "pad_oe", {62'd0, slice(pad_oe, q)}, {62'd0, m_oe[q]});
                end
                chk("R9", "rsp_valid", {79'd0, rsp_valid}, {79'd0, e_valid});
                if (e_valid) chk(e_tag, "rsp_data", {62'd0, rsp_data}, {62'd0, e_data});
            end
        end
    end

    task automatic issue(int op, int port, logic [17:0] data);
        @(posedge clk); #2;
        req_valid = 1'b1; req_op = 3'(op); req_port = 3'(port); req_data = data;
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        idle(2);
        // R2: write narrow port with all ones, bit 3 locked
        issue(0, 0, 18'h3FFFF);
        issue(6, 0, 18'h0);
        // R3 / R4: set and clear on wide ports
        issue(1, 1, 18'h3FFFF);
        issue(2, 1, 18'h0F0F0);
        issue(1, 2, 18'h12345);
        issue(2, 4, 18'h3FFFF);
        // R6 / R5: direction changes, top bit of port 4 locked
        issue(4, 4, 18'h3FFFF);
        issue(3, 4, 18'h20001);
        issue(4, 0, 18'h0FF);
        issue(3, 0, 18'h081);
        issue(7, 0, 18'h0);
        // R8: unused port indices
        issue(1, 5, 18'h3FFFF);
        issue(4, 7, 18'h3FFFF);
        // R7: pin read latency
        idle(1);
        pad_i = {72'h0, 8'h5A};
        issue(5, 0, 18'h0);
        issue(5, 0, 18'h0);
        issue(5, 0, 18'h0);
        idle(2);
        // Random traffic with random pins
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #2;
            req_valid = ($urandom_range(0, 9) < 8);
            req_op    = 3'($urandom_range(0, 7));
            req_port  = 3'($urandom_range(0, 7));
            req_data  = 18'($urandom);
            pad_i     = {16'($urandom), $urandom, $urandom};
        end
        idle(3);
        // R1: reset in mid-run
        #1 rst_n = 1'b0;
        idle(2);
        #1 rst_n = 1'b1;
        idle(3);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule